// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter that sits on a byte-wide host bus. The host writes one control byte, with chip select low, to pick an input channel, a range, unipolar or bipolar coding, a clock source and a power mode. The rising edge of that write starts a sampling phase. An internal counter times this phase, or a second host write ends it. A conversion phase then tests one result bit per conversion-clock enable, using a one-bit comparator input. The finished code goes into a result register, and an active-low interrupt tells the host that data is ready.

The host reads the result as two bytes, and `hben` chooses which one. The high byte is zero-filled for unipolar coding and sign-filled for bipolar coding. Two power-down codes in the control byte take effect only once the running conversion has finished. A dedicated shutdown input acts at once and cancels any conversion. The analog front end, the comparator and the clock oscillator are outside this block. Toward them the block presents a track strobe, a trial code and the latched channel, range and polarity fields.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `int_n` is 1, `int_clk_sel` is 0, `pwr_standby` and `pwr_full` are 0, `track` is 0 and `data_oe` is 0.
- R2: On a rising edge of `wr_n` with `cs_n` low, the block latches the control byte from `data_in`. The fields are: channel in bits 2..0, bipolar in bit 3, range in bit 4, host-timed sampling in bit 5, power/clock code in bits 7..6. The block presents the channel, range and bipolar fields on `chan_sel`, `range_hi` and `bipolar`. These outputs stay unchanged until the next accepted write.
- R3: A write with bit 5 = 0 raises `track` and starts an acquisition. The acquisition lasts exactly ACQ_CYCLES `conv_en` pulses (default 6) after the write edge. Conversion then begins by itself and `track` drops.
- R4: A write with bit 5 = 1 starts a tracking phase that no number of `conv_en` pulses ends. A further write with bit 5 = 1 keeps tracking. A further write with bit 5 = 0 ends tracking at its rising edge and starts conversion.
- R5: A conversion uses exactly 12 `conv_en` pulses. It tries bits from 11 down to 0 on `dac_code` and keeps each bit when `cmp_in` is 1. `int_n` falls at the 12th pulse and not before. The stored code is the largest value whose trial compared true.
- R6: A write during a conversion abandons that conversion and starts a new acquisition. No interrupt comes from the abandoned conversion.
- R7: `int_n` returns to 1 on a falling edge of `rd_n` with `cs_n` low, and on any accepted write.
- R8: With `hben` = 0, `data_out` carries result bits 7..0. With `hben` = 1, it carries result bits 11..8 in its low nibble. The upper nibble is filled with result bit 11 when bipolar is set and with 0 otherwise. `data_out` and `data_oe` are registered one clock after `cs_n`/`rd_n`/`hben`.
- R9: Code 00 in bits 7..6 selects the external clock (`int_clk_sel` = 0) and code 01 selects the internal clock (`int_clk_sel` = 1). Codes 10 and 11 leave `int_clk_sel` unchanged.
- R10: Code 10 sets `pwr_standby` and code 11 sets `pwr_full`, and each takes effect only when the conversion completes. In either mode the result stays readable on the bus.
- R11: A falling edge of `wr_n` with `cs_n` low returns the block from either power-down mode to normal operation.
- R12: `shdn_n` = 0 forces `pwr_full` on the next clock, drops `track` and abandons any conversion. Full power-down persists after `shdn_n` returns high, until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | Result byte select: 1 = high byte |
| shdn_n | input | 1 | Hardware shutdown, active low |
| data_in | input | 8 | Control byte from host |
| conv_en | input | 1 | Conversion clock enable, one pulse per conversion clock |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| data_out | output | 8 | Result byte to host |
| data_oe | output | 1 | Bus drive enable for data_out |
| int_n | output | 1 | Conversion done, active low |
| track | output | 1 | Track/hold control: 1 = tracking |
| dac_code | output | 12 | Trial code for the comparison DAC |
| chan_sel | output | 3 | Latched input channel |
| range_hi | output | 1 | Latched full-scale range select |
| bipolar | output | 1 | Latched bipolar coding select |
| int_clk_sel | output | 1 | 1 = internal conversion clock chosen |
| pwr_standby | output | 1 | Standby power-down active |
| pwr_full | output | 1 | Full power-down active |

## Verification
The bench builds the block with its defaults: RES_BITS = 12 and ACQ_CYCLES = 6. It drives `conv_en` one pulse at a time, so it can check the exact pulse at which tracking ends and the exact pulse at which the interrupt falls. A comparator model driven from `dac_code` makes the expected result the modelled input level. This lets the bench sweep every single-bit code, both end codes and a strided spread of others. With the 12-bit default, the bench can also sweep all 32 channel/range/polarity combinations and check sign fill in the high byte across both halves of the code space.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int BUS_W  = 8;
  localparam int CHAN_W = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ACQ_INT = 2'd1,
    SEQ_ACQ_EXT = 2'd2,
    SEQ_CONV    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_STBY = 2'd1,
    PWR_FULL = 2'd2
  } pwr_state_e;

  // Field order follows the byte layout decoded by the host (bit 7 first).
  typedef struct packed {
    logic [1:0]        pd;
    logic              acq_ext;
    logic              range_hi;
    logic              bipolar;
    logic [CHAN_W-1:0] chan;
  } ctrl_byte_t;

  localparam logic [1:0] PD_EXT_CLK = 2'b00;
  localparam logic [1:0] PD_INT_CLK = 2'b01;
  localparam logic [1:0] PD_STBY    = 2'b10;
  localparam logic [1:0] PD_FULL    = 2'b11;

endpackage

// File: rtl/adc_bus_port.sv
module adc_bus_port
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic                hben,
  input  logic [BUS_W-1:0]    data_in,
  input  logic [RES_BITS-1:0] result,
  input  logic                bipolar,
  output logic                wr_rise,
  output logic                wr_fall,
  output logic                rd_fall,
  output ctrl_byte_t          ctrl_in,
  output logic [BUS_W-1:0]    data_out,
  output logic                data_oe
);

  localparam int HI_W   = RES_BITS - BUS_W;
  localparam int FILL_W = BUS_W - HI_W;

  logic             wr_q;
  logic             rd_q;
  logic             sign_fill;
  logic [BUS_W-1:0] hi_byte;
  logic [BUS_W-1:0] lo_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  always_comb begin
    wr_rise   = !cs_n && !wr_q && wr_n;
    wr_fall   = !cs_n && wr_q && !wr_n;
    rd_fall   = !cs_n && rd_q && !rd_n;
    ctrl_in   = ctrl_byte_t'(data_in);
    sign_fill = bipolar & result[RES_BITS-1];
    lo_byte   = result[BUS_W-1:0];
    hi_byte   = {{FILL_W{sign_fill}}, result[RES_BITS-1:BUS_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      data_out <= hben ? hi_byte : lo_byte;
      data_oe  <= !cs_n && !rd_n;
    end
  end

  // R8
  oe_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> !data_oe);

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                start,
  input  logic                step,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] code,
  output logic [RES_BITS-1:0] result,
  output logic                done
);

  localparam int IDX_W = $clog2(RES_BITS);

  logic [RES_BITS-1:0] code_q;
  logic [RES_BITS-1:0] decided;
  logic [IDX_W-1:0]    idx_q;
  logic                busy_q;

  always_comb begin
    decided        = code_q;
    decided[idx_q] = cmp_in;
    done           = step && busy_q && (idx_q == '0);
    code           = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      result <= '0;
    end else if (clear) begin
      code_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      code_q <= {1'b1, {(RES_BITS-1){1'b0}}};
      idx_q  <= IDX_W'(RES_BITS-1);
      busy_q <= 1'b1;
    end else if (step && busy_q) begin
      if (idx_q == '0) begin
        code_q <= decided;
        result <= decided;
        busy_q <= 1'b0;
      end else begin
        code_q                <= decided;
        code_q[idx_q - 1'b1]  <= 1'b1;
        idx_q                 <= idx_q - 1'b1;
      end
    end
  end

  // R5
  trial_bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> code_q[idx_q]);

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !clear && !start) |=> !busy_q);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       shdn_n,
  input  logic       conv_en,
  input  logic       wr_rise,
  input  logic       wr_fall,
  input  logic       rd_fall,
  input  ctrl_byte_t ctrl_in,
  input  logic       sar_done,
  output logic       sar_start,
  output logic       sar_step,
  output logic       sar_clear,
  output ctrl_byte_t ctrl_q,
  output logic       track,
  output logic       int_n,
  output logic       int_clk,
  output pwr_state_e pwr
);

  localparam int CNT_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACQ_CYCLES - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] acq_cnt;
  logic             wr_ok;
  logic             acq_last;

  always_comb begin
    wr_ok     = wr_rise && shdn_n;
    acq_last  = (state == SEQ_ACQ_INT) && conv_en && (acq_cnt == CNT_LAST);
    sar_start = (shdn_n && acq_last && !wr_ok) ||
                (wr_ok && (state == SEQ_ACQ_EXT) && !ctrl_in.acq_ext);
    sar_step  = shdn_n && conv_en && (state == SEQ_CONV) && !wr_ok;
    sar_clear = !shdn_n || (wr_ok && (state == SEQ_CONV));
    track     = (state == SEQ_ACQ_INT) || (state == SEQ_ACQ_EXT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      acq_cnt <= '0;
      ctrl_q  <= '0;
      int_n   <= 1'b1;
      int_clk <= 1'b0;
      pwr     <= PWR_ON;
    end else if (!shdn_n) begin
      state   <= SEQ_IDLE;
      acq_cnt <= '0;
      pwr     <= PWR_FULL;
    end else begin
      if (wr_fall || wr_rise) pwr <= PWR_ON;
      if (wr_rise) begin
        ctrl_q  <= ctrl_in;
        int_n   <= 1'b1;
        acq_cnt <= '0;
        if (ctrl_in.pd == PD_EXT_CLK) int_clk <= 1'b0;
        else if (ctrl_in.pd == PD_INT_CLK) int_clk <= 1'b1;
        if (ctrl_in.acq_ext)            state <= SEQ_ACQ_EXT;
        else if (state == SEQ_ACQ_EXT)  state <= SEQ_CONV;
        else                            state <= SEQ_ACQ_INT;
      end else begin
        if (rd_fall) int_n <= 1'b1;
        case (state)
          SEQ_ACQ_INT: begin
            if (conv_en) begin
              if (acq_cnt == CNT_LAST) begin
                state   <= SEQ_CONV;
                acq_cnt <= '0;
              end else begin
                acq_cnt <= acq_cnt + 1'b1;
              end
            end
          end
          SEQ_CONV: begin
            if (sar_done) begin
              state <= SEQ_IDLE;
              int_n <= 1'b0;
              if (ctrl_q.pd == PD_STBY)      pwr <= PWR_STBY;
              else if (ctrl_q.pd == PD_FULL) pwr <= PWR_FULL;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  write_clears_int_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> int_n);

  // R12
  shdn_forces_full_chk: assert property (@(posedge clk) disable iff (rst)
    !shdn_n |=> (pwr == PWR_FULL) && !track);

  // R10
  pd_deferred_chk: assert property (@(posedge clk) disable iff (rst)
    (state != SEQ_IDLE) |-> (pwr == PWR_ON));

  // R3
  acq_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ACQ_INT) |-> (acq_cnt <= CNT_LAST));

  // R4
  ext_mode_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ACQ_EXT) |-> ctrl_q.acq_ext);

  // R2
  fields_held_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == SEQ_CONV) && !wr_rise) |=> $stable({ctrl_q.chan, ctrl_q.range_hi, ctrl_q.bipolar}));

  // R5
  int_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> $past(sar_done));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int ACQ_CYCLES = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic                hben,
  input  logic                shdn_n,
  input  logic [7:0]          data_in,
  input  logic                conv_en,
  input  logic                cmp_in,
  output logic [7:0]          data_out,
  output logic                data_oe,
  output logic                int_n,
  output logic                track,
  output logic [RES_BITS-1:0] dac_code,
  output logic [2:0]          chan_sel,
  output logic                range_hi,
  output logic                bipolar,
  output logic                int_clk_sel,
  output logic                pwr_standby,
  output logic                pwr_full
);

  logic                wr_rise;
  logic                wr_fall;
  logic                rd_fall;
  ctrl_byte_t          ctrl_in;
  ctrl_byte_t          ctrl_q;
  logic                sar_start;
  logic                sar_step;
  logic                sar_clear;
  logic                sar_done;
  logic [RES_BITS-1:0] result;
  pwr_state_e          pwr;

  adc_bus_port #(.RES_BITS(RES_BITS)) i_bus (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .hben     (hben),
    .data_in  (data_in),
    .result   (result),
    .bipolar  (ctrl_q.bipolar),
    .wr_rise  (wr_rise),
    .wr_fall  (wr_fall),
    .rd_fall  (rd_fall),
    .ctrl_in  (ctrl_in),
    .data_out (data_out),
    .data_oe  (data_oe)
  );

  adc_seq_fsm #(.ACQ_CYCLES(ACQ_CYCLES)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .shdn_n    (shdn_n),
    .conv_en   (conv_en),
    .wr_rise   (wr_rise),
    .wr_fall   (wr_fall),
    .rd_fall   (rd_fall),
    .ctrl_in   (ctrl_in),
    .sar_done  (sar_done),
    .sar_start (sar_start),
    .sar_step  (sar_step),
    .sar_clear (sar_clear),
    .ctrl_q    (ctrl_q),
    .track     (track),
    .int_n     (int_n),
    .int_clk   (int_clk_sel),
    .pwr       (pwr)
  );

  adc_sar_core #(.RES_BITS(RES_BITS)) i_sar (
    .clk    (clk),
    .rst    (rst),
    .clear  (sar_clear),
    .start  (sar_start),
    .step   (sar_step),
    .cmp_in (cmp_in),
    .code   (dac_code),
    .result (result),
    .done   (sar_done)
  );

  always_comb begin
    chan_sel    = ctrl_q.chan;
    range_hi    = ctrl_q.range_hi;
    bipolar     = ctrl_q.bipolar;
    pwr_standby = (pwr == PWR_STBY);
    pwr_full    = (pwr == PWR_FULL);
  end

  // R10
  single_pd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !(pwr_standby && pwr_full));

endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0, shdn_n = 1'b1;
  logic [7:0]  data_in = '0;
  logic        conv_en = 1'b0;
  logic        cmp_in;
  logic [7:0]  data_out;
  logic        data_oe, int_n, track, range_hi, bipolar, int_clk_sel, pwr_standby, pwr_full;
  logic [11:0] dac_code;
  logic [2:0]  chan_sel;
  logic [11:0] vin = '0;
  logic        mid_stby, mid_full;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_in = (dac_code <= vin);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .hben(hben),
    .shdn_n(shdn_n), .data_in(data_in), .conv_en(conv_en), .cmp_in(cmp_in),
    .data_out(data_out), .data_oe(data_oe), .int_n(int_n), .track(track),
    .dac_code(dac_code), .chan_sel(chan_sel), .range_hi(range_hi), .bipolar(bipolar),
    .int_clk_sel(int_clk_sel), .pwr_standby(pwr_standby), .pwr_full(pwr_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] b);
    @(negedge clk); cs_n = 1'b0; data_in = b; wr_n = 1'b0;
    @(negedge clk); mid_stby = pwr_standby; mid_full = pwr_full; wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); conv_en = 1'b1;
      @(negedge clk); conv_en = 1'b0;
    end
  endtask

  task automatic bus_read(input logic h, output logic [7:0] d, output logic oe);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; hben = h;
    @(negedge clk); d = data_out; oe = data_oe; rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic check_result(input string req, input logic [11:0] v, input logic bip);
    logic [7:0] d;
    logic oe;
    bus_read(1'b0, d, oe);
    chk({req, " low byte"}, int'(d), int'(v[7:0]));
    bus_read(1'b1, d, oe);
    chk({req, " high byte"}, int'(d), int'({{4{bip & v[11]}}, v[11:8]}));
  endtask

  task automatic convert(input logic [7:0] b, input logic [11:0] v);
    vin = v;
    bus_write(b);
    pulses(18);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    logic [11:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_n", int'(int_n), 1);
    chk("R1 int_clk_sel", int'(int_clk_sel), 0);
    chk("R1 power", int'({pwr_standby, pwr_full}), 0);
    chk("R1 track", int'(track), 0);
    chk("R1 data_oe", int'(data_oe), 0);

    // R3 internal acquisition length, R5 conversion length
    vin = 12'hA5C;
    bus_write(8'h05);
    chk("R3 track after write", int'(track), 1);
    pulses(5);
    chk("R3 track before last acq pulse", int'(track), 1);
    pulses(1);
    chk("R3 track ends after ACQ pulses", int'(track), 0);
    pulses(11);
    chk("R5 int_n before 12th pulse", int'(int_n), 1);
    pulses(1);
    chk("R5 int_n at 12th pulse", int'(int_n), 0);
    bus_read(1'b0, d, oe);
    chk("R8 low byte", int'(d), 'h5C);
    chk("R8 data_oe during read", int'(oe), 1);
    chk("R7 int_n cleared by read", int'(int_n), 1);
    bus_read(1'b1, d, oe);
    chk("R8 unipolar high byte", int'(d), 'h0A);

    // R2 / R8 sweep of channel, bipolar and range fields
    for (int c = 0; c < 32; c++) begin
      v = 12'((c * 131 + (c[0] ? 12'h800 : 12'h0)) & 12'hFFF);
      vin = v;
      bus_write({3'b000, 5'(c)});
      pulses(9);
      chk("R2 chan_sel mid conversion", int'(chan_sel), c & 7);
      chk("R2 bipolar mid conversion", int'(bipolar), (c >> 3) & 1);
      chk("R2 range_hi mid conversion", int'(range_hi), (c >> 4) & 1);
      pulses(9);
      chk("R5 int_n sweep", int'(int_n), 0);
      check_result("R8 field sweep", v, c[3]);
    end

    // R5 code sweep with bipolar coding
    for (int k = 0; k < 56; k++) begin
      if (k < 12) v = 12'(1 << k);
      else if (k == 12) v = 12'h000;
      else if (k == 13) v = 12'hFFF;
      else v = 12'(((k - 14) * 97 + 5) & 12'hFFF);
      convert(8'h08, v);
      check_result("R5 code sweep", v, 1'b1);
    end

    // R4 host-timed acquisition
    vin = 12'h123;
    bus_write(8'h22);
    chk("R4 track after ext write", int'(track), 1);
    pulses(20);
    chk("R4 track after many pulses", int'(track), 1);
    chk("R4 no interrupt while tracking", int'(int_n), 1);
    bus_write(8'h22);
    chk("R4 track after repeat ext write", int'(track), 1);
    pulses(3);
    bus_write(8'h02);
    chk("R4 second write ends tracking", int'(track), 0);
    pulses(11);
    chk("R4 int_n before 12th pulse", int'(int_n), 1);
    pulses(1);
    chk("R4 int_n after conversion", int'(int_n), 0);
    check_result("R4 result", 12'h123, 1'b0);

    // R6 abort by write during conversion
    vin = 12'h7FF;
    bus_write(8'h00);
    pulses(11);
    vin = 12'h400;
    bus_write(8'h01);
    chk("R6 track restarted", int'(track), 1);
    chk("R6 chan updated", int'(chan_sel), 1);
    pulses(17);
    chk("R6 no interrupt from aborted conversion", int'(int_n), 1);
    pulses(1);
    chk("R6 int_n after new conversion", int'(int_n), 0);
    check_result("R6 result", 12'h400, 1'b0);

    // R7 write clears int_n
    convert(8'h00, 12'h0F0);
    chk("R7 int_n low before write", int'(int_n), 0);
    bus_write(8'h00);
    chk("R7 int_n cleared by write", int'(int_n), 1);
    pulses(18);

    // R9 clock select, R10 standby, R11 wake
    bus_write(8'h40);
    chk("R9 internal clock selected", int'(int_clk_sel), 1);
    pulses(18);
    vin = 12'h321;
    bus_write(8'h80);
    chk("R9 standby code keeps clock", int'(int_clk_sel), 1);
    pulses(17);
    chk("R10 standby deferred", int'(pwr_standby), 0);
    pulses(1);
    chk("R10 standby after conversion", int'(pwr_standby), 1);
    check_result("R10 readable in standby", 12'h321, 1'b0);
    bus_write(8'h00);
    chk("R11 wake on write falling edge", int'(mid_stby), 0);
    chk("R9 external clock selected", int'(int_clk_sel), 0);
    pulses(18);

    // R10 full power-down, R11 wake
    convert(8'hC0, 12'h9AB);
    chk("R10 full power-down after conversion", int'(pwr_full), 1);
    chk("R9 full code keeps clock", int'(int_clk_sel), 0);
    check_result("R10 readable in full power-down", 12'h9AB, 1'b0);
    bus_write(8'h40);
    chk("R11 wake from full power-down", int'(mid_full), 0);
    pulses(18);

    // R12 hardware shutdown
    vin = 12'h555;
    bus_write(8'h00);
    pulses(10);
    @(negedge clk); shdn_n = 1'b0;
    @(negedge clk);
    chk("R12 full power-down immediate", int'(pwr_full), 1);
    chk("R12 track dropped", int'(track), 0);
    pulses(3);
    @(negedge clk); shdn_n = 1'b1;
    pulses(12);
    chk("R12 aborted conversion gives no interrupt", int'(int_n), 1);
    chk("R12 power-down persists after release", int'(pwr_full), 1);
    convert(8'h00, 12'h555);
    chk("R12 write wakes", int'(mid_full), 0);
    chk("R12 conversion after wake", int'(int_n), 0);
    check_result("R12 result after wake", 12'h555, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule